// File: doc/BRIEF.md
# Interrupt Code to Vector Translator

This block sits between the interrupt sources of a subsystem and a processor. Sources put a request code on `req_code`; every cycle in which that code is non-zero counts as one request. The block turns the code into a processor interrupt vector and holds one pending vector. It offers that vector on a valid/accept handshake and keeps offering it every cycle until the processor accepts it. The translation either passes the code straight through as the vector, or looks it up in a small programmable table of code/vector pairs.

A request can arrive while a different vector is still waiting to be delivered. A programmable collision policy then decides what happens: raise a fatal error, replace the pending vector with the newest one, or replace it with a fixed collision vector. A code that the enabled table cannot translate is also fatal. The error flag stays set until reset, and while it is set the block takes no new requests. Software sets up the table and the policy through a single-cycle register write port.

Top module: `irqx_xlate`

## Requirements
- R1: After reset `irq_valid` is low, `irq_vector` is zero and `err` is low. The table is disabled, the policy is abort and every table entry holds code zero.
- R2: A cycle with `req_code` equal to zero is not a request and leaves the pending vector unchanged.
- R3: While the table is disabled, a non-zero code is used unchanged as the vector.
- R4: While the table is enabled, a code is matched only against entries that come before the first entry whose code is zero. The lowest-indexed match supplies the vector.
- R5: While the table is enabled, a non-zero code with no match sets `err` and latches nothing.
- R6: A request whose vector equals the one already pending has no effect.
- R7: Under the abort policy (value 0, also used for value 3), a differing vector that arrives while another is pending sets `err` and leaves the pending vector as it was.
- R8: Under the newest policy (value 1), a differing vector replaces the pending one.
- R9: Under the fixed policy (value 2), a differing vector causes the programmed fixed vector to be latched.
- R10: `irq_valid` is high exactly while a non-zero vector is pending, and `irq_vector` carries that vector. A cycle with `irq_valid` and `irq_ack` both high clears the pending vector. A request in that same cycle is handled as if nothing were pending.
- R11: Once set, `err` stays high until reset. While it is high, requests are ignored, but the pending vector can still be accepted.
- R12: A write with `cfg_we` high to address i, for i below 8, stores code = `cfg_wdata[15:8]` and vector = `cfg_wdata[7:0]` in entry i. A write to address 8 sets the policy from bits [1:0], the table enable from bit 2 and the fixed vector from bits [15:8]. Writes to addresses 9 to 15 change nothing.
- R13: A request whose translated vector is zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: entries 0..7, control register at 8 |
| cfg_wdata | input | 16 | Configuration write data |
| req_code | input | 8 | Interrupt request code; zero means no request |
| irq_valid | output | 1 | A vector is pending |
| irq_vector | output | 8 | Pending vector |
| irq_ack | input | 1 | Processor accepts the offered vector |
| err | output | 1 | Sticky fatal error flag |

## Verification
The bench builds the block with its default parameters: eight entries, 8-bit codes and 8-bit vectors. With those values it can fill the table with a duplicate code, an entry whose vector is zero, a terminating zero code and a live-looking entry placed after that terminator, all within one configuration. This exercises the search order, the terminator rule and zero-vector dropping in a single table. The 4-bit address leaves room above the control register, so the bench can write to addresses that must be ignored. Each collision policy is tested from a fresh reset, which lets the sticky error be observed without carrying over between scenarios.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  // Collision policy applied when a differing vector meets a pending one.
  typedef enum logic [1:0] {
    POL_ABORT  = 2'd0,
    POL_NEWEST = 2'd1,
    POL_FIXED  = 2'd2
  } collide_pol_e;

  // Bit positions inside the control register write data.
  localparam int CTL_POL_LSB = 0;
  localparam int CTL_EN_BIT  = 2;

endpackage

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int VEC_W     = 8,
  parameter int CTRL_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [2:0]        ctl_bits,
  input  logic [VEC_W-1:0]  fix_in,
  output collide_pol_e      policy,
  output logic              tbl_en,
  output logic [VEC_W-1:0]  fix_vec
);

  logic         ctl_ld;
  collide_pol_e pol_d;
  collide_pol_e pol_q;
  logic         en_q;
  logic [VEC_W-1:0] fix_q;

  assign ctl_ld = cfg_we && (cfg_addr == ADDR_W'(CTRL_ADDR));

  // Encoding 3 is not a policy of its own and falls back to abort.
  always_comb begin
    case (ctl_bits[CTL_POL_LSB +: 2])
      2'd1:    pol_d = POL_NEWEST;
      2'd2:    pol_d = POL_FIXED;
      default: pol_d = POL_ABORT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= POL_ABORT;
      en_q  <= 1'b0;
      fix_q <= '0;
    end else if (ctl_ld) begin
      pol_q <= pol_d;
      en_q  <= ctl_bits[CTL_EN_BIT];
      fix_q <= fix_in;
    end
  end

  assign policy  = pol_q;
  assign tbl_en  = en_q;
  assign fix_vec = fix_q;

endmodule

// File: rtl/irqx_table.sv
module irqx_table #(
  parameter int ENTRIES = 8,
  parameter int CODE_W  = 8,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CODE_W+VEC_W-1:0]  cfg_wdata,
  input  logic [CODE_W-1:0]        req_code,
  output logic                     hit,
  output logic [VEC_W-1:0]         hit_vec
);

  localparam int DATA_W = CODE_W + VEC_W;

  logic [CODE_W-1:0] code_q [ENTRIES];
  logic [VEC_W-1:0]  vec_q  [ENTRIES];
  logic [ENTRIES-1:0] ent_we;
  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] match;

  // One write enable per entry, decoded from the address.
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_we
    assign ent_we[gi] = cfg_we && (cfg_addr == ADDR_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) begin
        code_q[k] <= '0;
        vec_q[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (ent_we[k]) begin
          code_q[k] <= cfg_wdata[DATA_W-1 -: CODE_W];
          vec_q[k]  <= cfg_wdata[VEC_W-1:0];
        end
      end
    end
  end

  // An entry is searched only if no zero code precedes it.
  always_comb begin
    live[0]  = (code_q[0] != '0);
    match[0] = live[0] && (code_q[0] == req_code);
    for (int k = 1; k < ENTRIES; k++) begin
      live[k]  = live[k-1] && (code_q[k] != '0);
      match[k] = live[k] && (code_q[k] == req_code);
    end
  end

  // The lowest index wins: scan downward so it is assigned last.
  always_comb begin
    hit     = 1'b0;
    hit_vec = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_vec = vec_q[k];
      end
    end
  end

endmodule

// File: rtl/irqx_pend.sv
module irqx_pend
  import irqx_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req_code,
  input  logic              tbl_en,
  input  collide_pol_e      policy,
  input  logic [VEC_W-1:0]  fix_vec,
  input  logic              hit,
  input  logic [VEC_W-1:0]  hit_vec,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              err
);

  logic [VEC_W-1:0] pend_q;
  logic [VEC_W-1:0] pend_d;
  logic             err_q;
  logic             err_d;
  logic             accept;
  logic             is_req;
  logic             miss;
  logic [VEC_W-1:0] base;
  logic [VEC_W-1:0] cand;
  logic             pend_ld;
  logic             err_ld;

  assign accept = (pend_q != '0) && irq_ack;
  assign base   = accept ? '0 : pend_q;
  assign is_req = (req_code != '0);
  assign miss   = is_req && tbl_en && !hit;
  assign cand   = tbl_en ? hit_vec : VEC_W'(req_code);

  always_comb begin
    pend_d = base;
    err_d  = err_q;
    if (!err_q && is_req) begin
      if (miss) begin
        err_d = 1'b1;
      end else if (cand == '0) begin
        pend_d = base;
      end else if ((base == '0) || (cand == base)) begin
        pend_d = cand;
      end else begin
        case (policy)
          POL_NEWEST: pend_d = cand;
          POL_FIXED:  pend_d = fix_vec;
          default:    err_d  = 1'b1;
        endcase
      end
    end
  end

  assign pend_ld = (pend_d != pend_q);
  assign err_ld  = (err_d != err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ld) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_ld) begin
      err_q <= err_d;
    end
  end

  assign irq_valid  = (pend_q != '0);
  assign irq_vector = pend_q;
  assign err        = err_q;

  // R2
  zero_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == '0 && !(irq_valid && irq_ack)) |=> $stable(pend_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R11
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(irq_valid && irq_ack)) |=> $stable(pend_q));

  // R5
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code != '0 && tbl_en && !hit) |=> err_q);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && req_code == '0) |=> !irq_valid);

  // R6
  same_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack && req_code != '0 && !tbl_en &&
     VEC_W'(req_code) == pend_q) |=> $stable(pend_q));

endmodule

// File: rtl/irqx_xlate.sv
module irqx_xlate
  import irqx_pkg::*;
#(
  parameter  int ENTRIES = 8,
  parameter  int CODE_W  = 8,
  parameter  int VEC_W   = 8,
  localparam int ADDR_W  = $clog2(ENTRIES) + 1,
  localparam int DATA_W  = CODE_W + VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [CODE_W-1:0] req_code,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  output logic              err
);

  collide_pol_e     policy;
  logic             tbl_en;
  logic [VEC_W-1:0] fix_vec;
  logic             hit;
  logic [VEC_W-1:0] hit_vec;

  irqx_ctrl #(
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W),
    .CTRL_ADDR (ENTRIES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .ctl_bits (cfg_wdata[2:0]),
    .fix_in   (cfg_wdata[DATA_W-1 -: VEC_W]),
    .policy   (policy),
    .tbl_en   (tbl_en),
    .fix_vec  (fix_vec)
  );

  irqx_table #(
    .ENTRIES (ENTRIES),
    .CODE_W  (CODE_W),
    .VEC_W   (VEC_W),
    .ADDR_W  (ADDR_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .req_code  (req_code),
    .hit       (hit),
    .hit_vec   (hit_vec)
  );

  irqx_pend #(
    .CODE_W (CODE_W),
    .VEC_W  (VEC_W)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_code   (req_code),
    .tbl_en     (tbl_en),
    .policy     (policy),
    .fix_vec    (fix_vec),
    .hit        (hit),
    .hit_vec    (hit_vec),
    .irq_ack    (irq_ack),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .err        (err)
  );

endmodule

// File: tb/sim_irqx_xlate.sv
`timescale 1ns/1ps
module sim_irqx_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  req_code = '0;
  logic        irq_ack = 1'b0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqx_xlate u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .req_code   (req_code),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_ack    (irq_ack),
    .err        (err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 1'b0;
    req_code = '0;
    irq_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic step(logic [7:0] code, logic ack);
    @(negedge clk);
    req_code = code;
    irq_ack = ack;
    @(posedge clk);
    #1;
    req_code = '0;
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 valid", irq_valid, 0);
    check("R1 vector", irq_vector, 0);
    check("R1 err", err, 0);
  endtask

  task automatic t_direct();
    do_reset();
    step(8'h25, 0);
    check("R3 vector", irq_vector, 8'h25);
    check("R10 valid", irq_valid, 1);
    step(8'h00, 0);
    step(8'h00, 0);
    check("R2 hold", irq_vector, 8'h25);
    check("R10 retry valid", irq_valid, 1);
    step(8'h25, 0);
    check("R6 vector", irq_vector, 8'h25);
    check("R6 err", err, 0);
    step(8'h00, 1);
    check("R10 cleared", irq_valid, 0);
    check("R10 vector zero", irq_vector, 0);
  endtask

  task automatic t_abort();
    do_reset();
    step(8'h11, 0);
    step(8'h22, 0);
    check("R7 err", err, 1);
    check("R7 kept", irq_vector, 8'h11);
    step(8'h33, 0);
    check("R11 ignored", irq_vector, 8'h11);
    step(8'h00, 1);
    check("R11 ack still works", irq_valid, 0);
    step(8'h44, 0);
    check("R11 no latch", irq_valid, 0);
    check("R11 sticky", err, 1);
  endtask

  task automatic t_newest();
    do_reset();
    wr(4'd8, 16'h0001);
    step(8'h11, 0);
    step(8'h22, 0);
    check("R8 replaced", irq_vector, 8'h22);
    check("R8 err", err, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    wr(4'd8, 16'h5A02);
    step(8'h11, 0);
    step(8'h22, 0);
    check("R9 fixed", irq_vector, 8'h5A);
    check("R9 err", err, 0);
  endtask

  task automatic t_table();
    do_reset();
    wr(4'd0, 16'h1081);
    wr(4'd1, 16'h2082);
    wr(4'd2, 16'h1099);
    wr(4'd3, 16'h3000);
    wr(4'd4, 16'h0000);
    wr(4'd5, 16'h5085);
    wr(4'd7, 16'h7787);
    wr(4'd8, 16'h0004);
    step(8'h10, 0);
    check("R4 first match", irq_vector, 8'h81);
    step(8'h00, 1);
    step(8'h20, 0);
    check("R12 entry1", irq_vector, 8'h82);
    step(8'h10, 1);
    check("R10 same-cycle ack", irq_vector, 8'h81);
    check("R10 same-cycle err", err, 0);
    step(8'h00, 1);
    step(8'h30, 0);
    check("R13 zero vector", irq_valid, 0);
    check("R13 err", err, 0);
    step(8'h50, 0);
    check("R4 after terminator err", err, 1);
    check("R5 nothing latched", irq_valid, 0);
  endtask

  task automatic t_miss();
    do_reset();
    wr(4'd0, 16'h1081);
    wr(4'd8, 16'h0004);
    step(8'h77, 0);
    check("R5 miss err", err, 1);
    check("R5 miss valid", irq_valid, 0);
  endtask

  task automatic t_bad_addr();
    do_reset();
    wr(4'd0, 16'h1081);
    wr(4'd9, 16'h0004);
    wr(4'd15, 16'h0004);
    step(8'h10, 0);
    check("R12 high addr ignored", irq_vector, 8'h10);
    check("R12 high addr err", err, 0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_abort();
    t_newest();
    t_fixed();
    t_table();
    t_miss();
    t_bad_addr();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule